// File: doc/BRIEF.md
# Compact-ISA register ALU executor

This block executes the register-to-register ALU group of a 16-bit compact instruction set. It recognises the group from the upper bits of the instruction word and hands the two 3-bit register indices to an external register file. It takes the destination and source operand values that come back, together with the incoming condition flags. From these it produces a 32-bit result, a register write strobe with its write-back index, and the updated flags.

Sixteen operations share the group: bitwise logic, shifts and rotation by a register amount, add and subtract with carry, negation, multiplication, and three compares that update only the flags. All evaluation is combinational. A parameter chooses whether the result, write strobe, write-back index and flags are registered, which adds one cycle of latency, or are driven straight from the logic. The register index outputs are always combinational, because the register file must be read in the same cycle.

Top module: `cxalu_exec`

## Requirements
- R1: The group is recognised only when instruction bits [15:10] equal 6'b010000. Otherwise `match_o` and `wr_en_o` are 0, `result_o` is 0 and `flags_o` equals `flags_i`.
- R2: `rs_idx_o` is instruction bits [5:3] and `rd_idx_o` is bits [2:0], combinationally. `wb_idx_o` carries bits [2:0] with the same latency as the result.
- R3: The operation code is instruction bits [9:6]. Logic codes are 0 AND, 1 EOR, 12 (hex C) OR, 14 (hex E) destination AND NOT source, and 15 (hex F) NOT source, which ignores the destination. Flags are packed {N,Z,C,V} in bits 3..0. Logic operations set N to result bit 31 and Z when the result is zero, and keep C and V.
- R4: Codes 8 (AND test), 10 (destination minus source) and 11 (destination plus source) update all applicable flags but never assert `wr_en_o`.
- R5: Code 5 adds destination, source and C. Code 6 computes destination minus source minus NOT C.
- R6: Code 9 writes 0 minus source and sets the flags as a subtraction.
- R7: For codes 5, 6, 9, 10 and 11, C is the unsigned carry out (for subtraction, 1 means no borrow) and V is the signed overflow.
- R8: Shift codes are 2 left, 3 logical right, 4 arithmetic right and 7 rotate right. The amount is the low 8 bits of the source only. An amount of 0 leaves the value and C unchanged. Otherwise C is the last bit shifted out, and V is kept.
- R9: A left or logical right shift by exactly 32 gives 0, with C equal to bit 0 (left) or bit 31 (right). Amounts above 32 give 0 with C equal to 0.
- R10: An arithmetic right shift by 32 or more fills every bit with the sign, with C equal to the sign. A rotation by a nonzero multiple of 32 keeps the value and sets C to bit 31. Other rotations use the amount modulo 32.
- R11: Code 13 (hex D) writes the low 32 bits of destination times source, sets N and Z, and keeps C and V.
- R12: With the output register enabled (default), outputs change one clock after the inputs. Reset (`rst_n` low, asynchronous) drives every registered output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word |
| rs_idx_o | output | 3 | Source register read index |
| rd_idx_o | output | 3 | Destination register read index |
| dst_i | input | 32 | Destination register value |
| src_i | input | 32 | Source register value |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| match_o | output | 1 | Instruction belongs to the group |
| wr_en_o | output | 1 | Register write strobe |
| wb_idx_o | output | 3 | Write-back register index |
| result_o | output | 32 | Operation result |
| flags_o | output | 4 | Updated flags {N,Z,C,V} |

## Verification
The bench targets shift amounts of 0, 31, 32 and 33, amounts whose low byte is zero while the upper bits are not, and rotations by 64. A shifter that used the full source word, or that dropped the separate handling of exactly 32, would produce a wrong value or carry in these cases. Borrow polarity is exercised by running subtraction with carry, compare and negate under both values of C on operands near the signed limits; an inverted borrow or an overflow test taken from the wrong operand shows up as a wrong C or V. The compare codes are checked for a low write strobe, and the logic, shift and multiply codes for V (and, for multiply, C) passing through from the input.

// File: rtl/cxalu_pkg.sv
package cxalu_pkg;

   localparam logic [5:0] GROUP_TAG = 6'b010000;

   typedef enum logic [3:0] {
      OP_AND = 4'h0, OP_EOR = 4'h1, OP_LSL = 4'h2, OP_LSR = 4'h3,
      OP_ASR = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_ROR = 4'h7,
      OP_TST = 4'h8, OP_NEG = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
      OP_ORR = 4'hC, OP_MUL = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
   } op_e;

   typedef enum logic [1:0] {
      CLS_LOGIC, CLS_SHIFT, CLS_ARITH, CLS_MUL
   } cls_e;

   typedef enum logic [1:0] {
      CIN_ZERO, CIN_ONE, CIN_FLAG
   } cin_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   typedef struct packed {
      logic       match;
      op_e        op;
      cls_e       cls;
      logic       wr_en;
      logic       a_zero;
      logic       b_inv;
      cin_e       cin;
      logic [2:0] rs;
      logic [2:0] rd;
   } ctrl_t;

endpackage

// File: rtl/cxalu_decode.sv
module cxalu_decode
   import cxalu_pkg::*;
(
   input  logic [15:0] instr_i,
   output ctrl_t       ctrl_o
);

   logic writes;

   always_comb begin
      ctrl_o       = '0;
      writes       = 1'b1;
      ctrl_o.match = (instr_i[15:10] == GROUP_TAG);
      ctrl_o.op    = op_e'(instr_i[9:6]);
      ctrl_o.rs    = instr_i[5:3];
      ctrl_o.rd    = instr_i[2:0];
      ctrl_o.cls   = CLS_LOGIC;
      ctrl_o.cin   = CIN_ZERO;
      unique case (ctrl_o.op)
         OP_AND, OP_EOR, OP_ORR, OP_BIC, OP_MVN: ctrl_o.cls = CLS_LOGIC;
         OP_TST: begin
            ctrl_o.cls = CLS_LOGIC;
            writes     = 1'b0;
         end
         OP_LSL, OP_LSR, OP_ASR, OP_ROR: ctrl_o.cls = CLS_SHIFT;
         OP_ADC: begin
            ctrl_o.cls = CLS_ARITH;
            ctrl_o.cin = CIN_FLAG;
         end
         OP_SBC: begin
            ctrl_o.cls   = CLS_ARITH;
            ctrl_o.b_inv = 1'b1;
            ctrl_o.cin   = CIN_FLAG;
         end
         OP_CMP: begin
            ctrl_o.cls   = CLS_ARITH;
            ctrl_o.b_inv = 1'b1;
            ctrl_o.cin   = CIN_ONE;
            writes       = 1'b0;
         end
         OP_CMN: begin
            ctrl_o.cls = CLS_ARITH;
            writes     = 1'b0;
         end
         OP_NEG: begin
            ctrl_o.cls    = CLS_ARITH;
            ctrl_o.a_zero = 1'b1;
            ctrl_o.b_inv  = 1'b1;
            ctrl_o.cin    = CIN_ONE;
         end
         OP_MUL: ctrl_o.cls = CLS_MUL;
         default: ctrl_o.cls = CLS_LOGIC;
      endcase
      ctrl_o.wr_en = ctrl_o.match & writes;
   end

endmodule

// File: rtl/cxalu_shift.sv
module cxalu_shift
   import cxalu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  op_e               op_i,
   input  logic [DATA_W-1:0] val_i,
   input  logic [7:0]        amt_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cout_o
);

   localparam int SH_W = $clog2(DATA_W);

   logic [DATA_W:0]     lsl_ext;
   logic [DATA_W:0]     lsr_ext;
   logic [DATA_W:0]     asr_ext;
   logic [2*DATA_W-1:0] rot_ext;

   // One extra bit beside the value catches the last bit shifted out;
   // amounts at or beyond the width fall out of the same expression.
   always_comb begin
      lsl_ext = {1'b0, val_i} << amt_i;
      lsr_ext = {val_i, 1'b0} >> amt_i;
      asr_ext = $signed({val_i, 1'b0}) >>> amt_i;
      rot_ext = {val_i, val_i} >> amt_i[SH_W-1:0];
   end

   always_comb begin
      res_o  = val_i;
      cout_o = cin_i;
      if (amt_i != 8'd0) begin
         unique case (op_i)
            OP_LSL: {cout_o, res_o} = lsl_ext;
            OP_LSR: {res_o, cout_o} = lsr_ext;
            OP_ASR: {res_o, cout_o} = asr_ext;
            default: begin
               res_o  = rot_ext[DATA_W-1:0];
               cout_o = rot_ext[DATA_W-1];
            end
         endcase
      end
   end

endmodule

// File: rtl/cxalu_addsub.sv
module cxalu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic              a_zero_i,
   input  logic              b_inv_i,
   input  logic              cin_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o,
   output logic              v_o
);

   logic [DATA_W-1:0] opa;
   logic [DATA_W-1:0] opb;
   logic [DATA_W:0]   sum;

   always_comb begin
      opa   = a_zero_i ? '0 : dst_i;
      opb   = b_inv_i ? ~src_i : src_i;
      sum   = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin_i};
      res_o = sum[DATA_W-1:0];
      c_o   = sum[DATA_W];
      v_o   = (opa[DATA_W-1] == opb[DATA_W-1]) &&
              (sum[DATA_W-1] != opa[DATA_W-1]);
   end

endmodule

// File: rtl/cxalu_logic.sv
module cxalu_logic
   import cxalu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  op_e               op_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   output logic [DATA_W-1:0] res_o
);

   logic [DATA_W-1:0] prod;

   always_comb begin
      prod = dst_i * src_i;
      unique case (op_i)
         OP_AND, OP_TST: res_o = dst_i & src_i;
         OP_EOR:         res_o = dst_i ^ src_i;
         OP_ORR:         res_o = dst_i | src_i;
         OP_BIC:         res_o = dst_i & ~src_i;
         OP_MVN:         res_o = ~src_i;
         OP_MUL:         res_o = prod;
         default:        res_o = '0;
      endcase
   end

endmodule

// File: rtl/cxalu_exec.sv
module cxalu_exec
   import cxalu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       instr_i,
   output logic [2:0]        rs_idx_o,
   output logic [2:0]        rd_idx_o,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [3:0]        flags_i,
   output logic              match_o,
   output logic              wr_en_o,
   output logic [2:0]        wb_idx_o,
   output logic [DATA_W-1:0] result_o,
   output logic [3:0]        flags_o
);

   generate
      if (DATA_W < 8 || DATA_W > 128 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("cxalu_exec: DATA_W must be a power of two from 8 to 128");
      end
   endgenerate

   ctrl_t             ctrl;
   flags_t            fin;
   flags_t            fnext;
   logic              add_cin;
   logic [DATA_W-1:0] lg_res;
   logic [DATA_W-1:0] sh_res;
   logic              sh_c;
   logic [DATA_W-1:0] as_res;
   logic              as_c;
   logic              as_v;
   logic [DATA_W-1:0] res_next;

   assign fin = flags_t'(flags_i);

   cxalu_decode u_decode (
      .instr_i (instr_i),
      .ctrl_o  (ctrl)
   );

   assign rs_idx_o = ctrl.rs;
   assign rd_idx_o = ctrl.rd;

   always_comb begin
      unique case (ctrl.cin)
         CIN_ONE:  add_cin = 1'b1;
         CIN_FLAG: add_cin = fin.c;
         default:  add_cin = 1'b0;
      endcase
   end

   cxalu_logic #(.DATA_W(DATA_W)) u_logic (
      .op_i  (ctrl.op),
      .dst_i (dst_i),
      .src_i (src_i),
      .res_o (lg_res)
   );

   cxalu_shift #(.DATA_W(DATA_W)) u_shift (
      .op_i   (ctrl.op),
      .val_i  (dst_i),
      .amt_i  (src_i[7:0]),
      .cin_i  (fin.c),
      .res_o  (sh_res),
      .cout_o (sh_c)
   );

   cxalu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a_zero_i (ctrl.a_zero),
      .b_inv_i  (ctrl.b_inv),
      .cin_i    (add_cin),
      .dst_i    (dst_i),
      .src_i    (src_i),
      .res_o    (as_res),
      .c_o      (as_c),
      .v_o      (as_v)
   );

   always_comb begin
      fnext = fin;
      unique case (ctrl.cls)
         CLS_SHIFT: begin
            res_next = sh_res;
            fnext.c  = sh_c;
         end
         CLS_ARITH: begin
            res_next = as_res;
            fnext.c  = as_c;
            fnext.v  = as_v;
         end
         default: res_next = lg_res;
      endcase
      fnext.n = res_next[DATA_W-1];
      fnext.z = (res_next == '0);
      if (!ctrl.match) begin
         res_next = '0;
         fnext    = fin;
      end
   end

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               match_o  <= 1'b0;
               wr_en_o  <= 1'b0;
               wb_idx_o <= '0;
               result_o <= '0;
               flags_o  <= '0;
            end else begin
               match_o  <= ctrl.match;
               wr_en_o  <= ctrl.wr_en;
               wb_idx_o <= ctrl.rd;
               result_o <= res_next;
               flags_o  <= fnext;
            end
         end
      end else begin : g_out_comb
         assign match_o  = ctrl.match;
         assign wr_en_o  = ctrl.wr_en;
         assign wb_idx_o = ctrl.rd;
         assign result_o = res_next;
         assign flags_o  = fnext;
      end
   endgenerate

endmodule

// File: rtl/cxalu_exec_chk.sv
module cxalu_exec_chk #(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [15:0]       instr_i,
   input logic [DATA_W-1:0] dst_i,
   input logic [DATA_W-1:0] src_i,
   input logic [3:0]        flags_i,
   input logic              match_o,
   input logic              wr_en_o,
   input logic [DATA_W-1:0] result_o,
   input logic [3:0]        flags_o
);

   logic [15:0]       ins_q;
   logic [DATA_W-1:0] dst_q;
   logic [DATA_W-1:0] src_q;
   logic [3:0]        flg_q;
   logic [3:0]        op_q;

   generate
      if (OUT_REG) begin : g_align
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ins_q <= '0;
               dst_q <= '0;
               src_q <= '0;
               flg_q <= '0;
            end else begin
               ins_q <= instr_i;
               dst_q <= dst_i;
               src_q <= src_i;
               flg_q <= flags_i;
            end
         end
      end else begin : g_direct
         assign ins_q = instr_i;
         assign dst_q = dst_i;
         assign src_q = src_i;
         assign flg_q = flags_i;
      end
   endgenerate

   assign op_q = ins_q[9:6];

   AST_OUTSIDE_GROUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !match_o |-> (!wr_en_o && flags_o == flg_q && result_o == '0)); // R1

   AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && (op_q == 4'h8 || op_q == 4'hA || op_q == 4'hB)) |-> !wr_en_o); // R4

   AST_ZERO_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> (flags_o[2] == (result_o == '0))); // R3

   AST_NON_ARITH_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && !(op_q == 4'h5 || op_q == 4'h6 || op_q == 4'h9 ||
                    op_q == 4'hA || op_q == 4'hB)) |-> (flags_o[0] == flg_q[0])); // R3

   AST_ZERO_SHIFT_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && (op_q == 4'h2 || op_q == 4'h3 || op_q == 4'h4 || op_q == 4'h7) &&
       src_q[7:0] == 8'd0) |-> (result_o == dst_q && flags_o[1] == flg_q[1])); // R8

   AST_MUL_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && op_q == 4'hD) |-> (flags_o[1] == flg_q[1] && wr_en_o)); // R11

endmodule

bind cxalu_exec cxalu_exec_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_cxalu_exec_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .instr_i  (instr_i),
   .dst_i    (dst_i),
   .src_i    (src_i),
   .flags_i  (flags_i),
   .match_o  (match_o),
   .wr_en_o  (wr_en_o),
   .result_o (result_o),
   .flags_o  (flags_o)
);

// File: tb/cxalu_exec_bench.sv
`timescale 1ns/1ps
module cxalu_exec_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr_i = '0;
   logic [31:0] dst_i = '0;
   logic [31:0] src_i = '0;
   logic [3:0]  flags_i = '0;
   logic [2:0]  rs_idx_o, rd_idx_o, wb_idx_o;
   logic        match_o, wr_en_o;
   logic [31:0] result_o;
   logic [3:0]  flags_o;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   cxalu_exec u_cxalu_exec (
      .clk(clk), .rst_n(rst_n), .instr_i(instr_i),
      .rs_idx_o(rs_idx_o), .rd_idx_o(rd_idx_o),
      .dst_i(dst_i), .src_i(src_i), .flags_i(flags_i),
      .match_o(match_o), .wr_en_o(wr_en_o), .wb_idx_o(wb_idx_o),
      .result_o(result_o), .flags_o(flags_o)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   // {C, V, result}
   function automatic logic [33:0] add_m(input logic [31:0] a, b, input logic ci);
      logic [63:0] u;
      longint      s;
      u = {32'b0, a} + {32'b0, b} + {63'b0, ci};
      s = longint'($signed(a)) + longint'($signed(b)) + longint'({63'b0, ci});
      return {u[32], (s > 64'sd2147483647 || s < -64'sd2147483648), u[31:0]};
   endfunction

   function automatic logic [33:0] sub_m(input logic [31:0] a, b, input logic brw);
      logic        c;
      longint      s;
      logic [31:0] r;
      r = a - b - {31'b0, brw};
      c = ({32'b0, a} >= ({32'b0, b} + {63'b0, brw}));
      s = longint'($signed(a)) - longint'($signed(b)) - longint'({63'b0, brw});
      return {c, (s > 64'sd2147483647 || s < -64'sd2147483648), r};
   endfunction

   // {C, result}
   function automatic logic [32:0] shf_m(input int op, input logic [31:0] d,
                                         input int n, input logic c);
      int k;
      if (n == 0) return {c, d};
      case (op)
         2: if (n < 32) return {d[32-n], d << n};
            else if (n == 32) return {d[0], 32'b0};
            else return 33'b0;
         3: if (n < 32) return {d[n-1], d >> n};
            else if (n == 32) return {d[31], 32'b0};
            else return 33'b0;
         4: if (n < 32) return {d[n-1], 32'($signed(d) >>> n)};
            else return {d[31], {32{d[31]}}};
         default: begin
            k = n % 32;
            if (k == 0) return {d[31], d};
            return {d[k-1], (d >> k) | (d << (32 - k))};
         end
      endcase
   endfunction

   task automatic model(input int op, input logic [31:0] d, s, input logic [3:0] f,
                        output logic [31:0] r, output logic we, output logic [3:0] fo);
      logic [33:0] a;
      logic [32:0] h;
      logic        c, v;
      c = f[1];
      v = f[0];
      we = !(op == 8 || op == 10 || op == 11);
      case (op)
         0, 8: r = d & s;
         1:    r = d ^ s;
         12:   r = d | s;
         14:   r = d & ~s;
         15:   r = ~s;
         13:   r = d * s;
         2, 3, 4, 7: begin h = shf_m(op, d, int'(s[7:0]), f[1]); {c, r} = h; end
         5:    begin a = add_m(d, s, f[1]);   {c, v, r} = a; end
         11:   begin a = add_m(d, s, 1'b0);   {c, v, r} = a; end
         6:    begin a = sub_m(d, s, !f[1]);  {c, v, r} = a; end
         10:   begin a = sub_m(d, s, 1'b0);   {c, v, r} = a; end
         default: begin a = sub_m(32'd0, s, 1'b0); {c, v, r} = a; end
      endcase
      fo = {r[31], (r == 32'd0), c, v};
   endtask

   function automatic string tag_of(input int op, input logic [31:0] s);
      case (op)
         0, 1, 12, 14, 15: return "R3";
         8, 10, 11:        return "R4 R7";
         5, 6:             return "R5 R7";
         9:                return "R6 R7";
         13:               return "R11";
         2, 3: return (s[7:0] == 8'd0 || s[31:8] != 0) ? "R8" : "R9";
         default: return (s[7:0] == 8'd0 || s[31:8] != 0) ? "R8" : "R10";
      endcase
   endfunction

   logic [31:0] dlist [8] = '{32'h0, 32'h1, 32'h8000_0000, 32'h7FFF_FFFF,
                              32'hFFFF_FFFF, 32'h1234_5678, 32'hF0F0_0F0F, 32'hA5A5_5A5A};
   logic [31:0] slist [13] = '{32'h0, 32'h1, 32'h4, 32'h1F, 32'h20, 32'h21, 32'h40,
                               32'hFF, 32'h100, 32'h120, 32'h8000_0000,
                               32'hFFFF_FFFF, 32'h7FFF_FFFF};

   initial begin
      logic [31:0] er;
      logic        ewe;
      logic [3:0]  ef;

      #2;
      n_chk++;   // R12 reset state
      if (match_o || wr_en_o || wb_idx_o != 0 || result_o != 0 || flags_o != 0) begin
         n_bad++;
         $display("FAIL R12 reset: actual m%b w%b i%0d r%h f%h expected all zero",
                  match_o, wr_en_o, wb_idx_o, result_o, flags_o);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 latency: no change before the clock edge
      @(negedge clk);
      instr_i = {6'b010000, 4'hF, 3'd2, 3'd5};
      src_i = 32'h0;
      dst_i = 32'h55;
      flags_i = 4'b0011;
      @(posedge clk);
      #1;
      n_chk++;
      if (result_o != 32'hFFFF_FFFF || !wr_en_o || wb_idx_o != 3'd5) begin
         n_bad++;
         $display("FAIL R12 latency: actual r%h w%b i%0d expected r%h w1 i5",
                  result_o, wr_en_o, wb_idx_o, 32'hFFFF_FFFF);
      end

      // R1: every other value of the top six bits
      for (int hi = 0; hi < 64; hi++) begin
         if (hi == 16) continue;
         @(negedge clk);
         instr_i = {6'(hi), 10'h2A5};
         dst_i = 32'h1357_9BDF;
         src_i = 32'h2;
         flags_i = 4'(hi);
         @(negedge clk);
         n_chk++;
         if (match_o || wr_en_o || result_o != 0 || flags_o != 4'(hi)) begin
            n_bad++;
            $display("FAIL R1 tag %0d: actual m%b w%b r%h f%h expected m0 w0 r0 f%h",
                     hi, match_o, wr_en_o, result_o, flags_o, 4'(hi));
         end
      end

      // Main sweep over all codes, operand patterns and flag inputs
      for (int op = 0; op < 16; op++) begin
         for (int di = 0; di < 8; di++) begin
            for (int si = 0; si < 13; si++) begin
               for (int fl = 0; fl < 16; fl++) begin
                  @(negedge clk);
                  instr_i = {6'b010000, 4'(op), 3'((si + fl) % 8), 3'((di + si) % 8)};
                  dst_i = dlist[di];
                  src_i = slist[si];
                  flags_i = 4'(fl);
                  #1;
                  if (fl == 0) begin
                     n_chk++;
                     if (rs_idx_o != 3'((si + fl) % 8) || rd_idx_o != 3'((di + si) % 8)) begin
                        n_bad++;
                        $display("FAIL R2 index: actual rs%0d rd%0d expected rs%0d rd%0d",
                                 rs_idx_o, rd_idx_o, (si + fl) % 8, (di + si) % 8);
                     end
                  end
                  model(op, dlist[di], slist[si], 4'(fl), er, ewe, ef);
                  @(negedge clk);
                  n_chk++;
                  if (!match_o || wr_en_o != ewe || result_o != er || flags_o != ef ||
                      wb_idx_o != 3'((di + si) % 8)) begin
                     n_bad++;
                     $display("FAIL %s op%h d%h s%h f%h: actual r%h w%b f%h i%0d expected r%h w%b f%h i%0d",
                              tag_of(op, slist[si]), op, dlist[di], slist[si], fl,
                              result_o, wr_en_o, flags_o, wb_idx_o,
                              er, ewe, ef, (di + si) % 8);
                  end
               end
            end
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule